// File: doc/BRIEF.md
# Programmable dual-modulus prescaler

The block divides a fast input clock by P or by P+1. A 2-bit setting picks P from 8, 16, 32 and 64. A modulus-control input picks the extra count for each output period. Inside is a synchronous divide-by-4/5 core. It is followed by one to four binary stages, and the setting decides how many of those stages take part. The core inserts its fifth cycle only during the last core sub-period of an output period. As a result each output period that asks for P+1 gains exactly one input cycle. The divided result drives the downstream swallow and main counters in two forms: a one-cycle tick that marks the last input cycle of each output period, and a waveform that is high for the first half of the period.

The setting and the modulus control are captured together in the first input cycle of each output period. A change later in the period only takes effect in the next one. A synchronous reset clears every stage. The cycle right after the last reset edge is the first cycle of a new period.

Period phase machine (`phase_t`):
- PH_LOAD: the first cycle of a period, during which the inputs are captured. It always moves to PH_RUN.
- PH_RUN: stays in PH_RUN until the tick, then returns to PH_LOAD.

Core machine (`core_st_t`):
- CORE_Q0 → CORE_Q1 → CORE_Q2 → CORE_Q3 in sequence.
- CORE_Q3 → CORE_XTRA when a swallow is requested. Otherwise CORE_Q3 → CORE_Q0.
- CORE_XTRA → CORE_Q0.

Reset forces PH_LOAD and CORE_Q0.

Top module: `prsc_top`

## Requirements
- R1: With `mod_hi` low at the start of a period, the period lasts P input cycles, where P is 8 for `cfg_sel`=2'b00, 16 for 2'b01, 32 for 2'b10 and 64 for 2'b11.
- R2: With `mod_hi` high at the start of a period, the period lasts P+1 input cycles.
- R3: `mod_hi` is sampled only in the first cycle of a period. Values it takes in any other cycle do not change that period's length.
- R4: `cfg_sel` is sampled only in the first cycle of a period. Values it takes in any other cycle do not change that period's length or waveform.
- R5: `o_tick` is high for exactly one cycle per period, the last one. The next cycle starts a new period.
- R6: `o_wave` is high during the first P/2 cycles of a period and low for the rest, so the extra cycle always falls in the low half.
- R7: While `rst` is high at clock edges, `o_tick` is low and `o_wave` is high. The cycle after the last reset edge is the first cycle of a period, and that period's length follows R1/R2 using the inputs sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sel | input | 2 | Ratio setting: 00=8/9, 01=16/17, 10=32/33, 11=64/65 |
| mod_hi | input | 1 | Modulus control: 1 selects P+1 for the period being started |
| o_tick | output | 1 | High in the last input cycle of each output period |
| o_wave | output | 1 | Divided clock, high for the first P/2 cycles of a period |

## Verification
The bench builds the block with its default parameters: a 2-bit setting and four trailing binary stages. This brings all four ratios and both moduli within reach, including the 65-cycle period in which all four stages take part. A behavioural model that counts cycles alone predicts the tick and the waveform on every clock. It is driven by steady settings, by modulus control and setting values that change every cycle, and by a reset in the middle of a period.

// File: rtl/prsc_pkg.sv
package prsc_pkg;

    // Width of the ratio setting field.
    localparam int unsigned SEL_W   = 2;
    // Number of trailing binary stages needed for the largest setting.
    localparam int unsigned STG_MAX = 2 ** SEL_W;

    // Divide-by-4/5 core states.
    typedef enum logic [2:0] {
        CORE_Q0,
        CORE_Q1,
        CORE_Q2,
        CORE_Q3,
        CORE_XTRA
    } core_st_t;

    // Output period phases.
    typedef enum logic {
        PH_LOAD,
        PH_RUN
    } phase_t;

endpackage

// File: rtl/prsc_core.sv
module prsc_core
    import prsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic swallow_req,
    output logic core_end,
    output logic in_xtra
);

    core_st_t st_q, st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) st_q <= CORE_Q0;
        else     st_q <= st_d;
    end

    // Next state.
    always_comb begin
        st_d = CORE_Q0;
        unique case (st_q)
            CORE_Q0:   st_d = CORE_Q1;
            CORE_Q1:   st_d = CORE_Q2;
            CORE_Q2:   st_d = CORE_Q3;
            CORE_Q3:   st_d = swallow_req ? CORE_XTRA : CORE_Q0;
            CORE_XTRA: st_d = CORE_Q0;
            default:   st_d = CORE_Q0;
        endcase
    end

    // Outputs.
    always_comb begin
        core_end = 1'b0;
        in_xtra  = 1'b0;
        unique case (st_q)
            CORE_Q3:   core_end = !swallow_req;
            CORE_XTRA: begin
                core_end = 1'b1;
                in_xtra  = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: the extra state is only ever entered from the fourth state.
    a_r2_xtra_follows_q3: assert property (@(posedge clk) disable iff (rst)
        (st_q == CORE_XTRA) |-> ($past(st_q) == CORE_Q3));

    // R5: a sub-period ends at most once in a row.
    a_r5_core_end_spacing: assert property (@(posedge clk) disable iff (rst)
        core_end |=> !core_end);

endmodule

// File: rtl/prsc_stages.sv
module prsc_stages #(
    parameter int unsigned SEL_W = prsc_pkg::SEL_W,
    parameter int unsigned STG_N = prsc_pkg::STG_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             last,
    output logic             half_hi
);

    logic [STG_N-1:0] q;
    logic [STG_N:0]   carry;
    logic [STG_N-1:0] mask;
    logic             wrap;

    assign carry[0] = adv;
    assign wrap     = adv && last;

    // One toggle stage per bit, each enabled by the carry out of the bits below it.
    for (genvar i = 0; i < STG_N; i++) begin : g_stage
        assign carry[i+1] = carry[i] & q[i];
        assign mask[i]    = (sel >= SEL_W'(i));
        always_ff @(posedge clk) begin
            if (rst || wrap)   q[i] <= 1'b0;
            else if (carry[i]) q[i] <= ~q[i];
        end
    end

    assign last    = &(q | ~mask);
    assign half_hi = !q[sel];

    // R1: no stage above the selected count ever leaves zero.
    a_r1_width_bound: assert property (@(posedge clk) disable iff (rst)
        ((q & ~mask) == '0));

endmodule

// File: rtl/prsc_top.sv
module prsc_top
    import prsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic                 mod_hi,
    output logic                 o_tick,
    output logic                 o_wave
);

    phase_t           ph_q, ph_d;
    logic [SEL_W-1:0] cfg_q;
    logic             mod_q;
    logic [SEL_W-1:0] sel_eff;
    logic             stg_last;
    logic             stg_half;
    logic             core_end;
    logic             in_xtra;
    logic             swallow_req;

    // Phase register.
    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_LOAD;
        else     ph_q <= ph_d;
    end

    // Next phase.
    always_comb begin
        ph_d = PH_RUN;
        unique case (ph_q)
            PH_LOAD: ph_d = PH_RUN;
            PH_RUN:  ph_d = o_tick ? PH_LOAD : PH_RUN;
            default: ph_d = PH_LOAD;
        endcase
    end

    // Capture the setting and the modulus in the first cycle of a period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            mod_q <= 1'b0;
        end else if (ph_q == PH_LOAD) begin
            cfg_q <= cfg_sel;
            mod_q <= mod_hi;
        end
    end

    assign sel_eff     = (ph_q == PH_LOAD) ? cfg_sel : cfg_q;
    assign swallow_req = mod_q && stg_last;

    prsc_core u_core (
        .clk         (clk),
        .rst         (rst),
        .swallow_req (swallow_req),
        .core_end    (core_end),
        .in_xtra     (in_xtra)
    );

    prsc_stages #(
        .SEL_W (SEL_W),
        .STG_N (STG_MAX)
    ) u_stages (
        .clk     (clk),
        .rst     (rst),
        .adv     (core_end),
        .sel     (sel_eff),
        .last    (stg_last),
        .half_hi (stg_half)
    );

    // Outputs.
    always_comb begin
        o_tick = core_end && stg_last;
        o_wave = stg_half;
    end

    // R5: a tick is followed by the first cycle of the next period.
    a_r5_tick_then_load: assert property (@(posedge clk) disable iff (rst)
        o_tick |=> (ph_q == PH_LOAD));

    // R5: ticks never come in adjacent cycles.
    a_r5_tick_single: assert property (@(posedge clk) disable iff (rst)
        o_tick |=> !o_tick);

    // R6: the waveform is high in the first cycle of every period.
    a_r6_wave_at_load: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_LOAD) |-> o_wave);

    // R2: the extra core cycle only happens when P+1 was captured.
    a_r2_xtra_needs_mod: assert property (@(posedge clk) disable iff (rst)
        in_xtra |-> mod_q);

    // R7: the cycle after reset is a period start with no tick.
    a_r7_start_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((ph_q == PH_LOAD) && !o_tick));

endmodule

// File: tb/tb_prsc_top.sv
module tb_prsc_top;

    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_sel = 2'b00;
    logic       mod_hi = 1'b0;
    logic       o_tick;
    logic       o_wave;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Behavioural model state.
    int    cnt  = 0;
    int    plen = 8;
    int    pval = 8;
    int    meas = 0;
    bit    cur_mod = 0;
    bit    first_after_rst = 0;
    string tick_tag = "R5";

    always #(CLK_NS/2) clk = ~clk;

    prsc_top dut (
        .clk     (clk),
        .rst     (rst),
        .cfg_sel (cfg_sel),
        .mod_hi  (mod_hi),
        .o_tick  (o_tick),
        .o_wave  (o_wave)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Begin a model period with the inputs just driven.
    task automatic open_period(input bit m, input logic [1:0] c);
        pval    = 8 << int'(c);
        plen    = pval + int'(m);
        cur_mod = m;
    endtask

    // One input cycle: check outputs, drive next inputs, advance the model.
    task automatic step(input bit m, input logic [1:0] c);
        @(negedge clk);
        chk(o_tick === (cnt == plen - 1), tick_tag, int'(o_tick), int'(cnt == plen - 1));
        chk(o_wave === (cnt < pval / 2), "R6", int'(o_wave), int'(cnt < pval / 2));
        if (o_tick === 1'b1) begin
            if (first_after_rst)
                chk(meas + 1 == plen, "R7", meas + 1, plen);
            else if (cur_mod)
                chk(meas + 1 == plen, "R2", meas + 1, plen);
            else
                chk(meas + 1 == plen, "R1", meas + 1, plen);
            meas = 0;
            first_after_rst = 0;
        end else begin
            meas++;
        end
        mod_hi  = m;
        cfg_sel = c;
        if (cnt == 0) open_period(m, c);
        cnt = (cnt == plen - 1) ? 0 : cnt + 1;
    endtask

    // Reset for a few edges; release with the inputs for the first period.
    task automatic do_reset(input bit m, input logic [1:0] c);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(o_tick === 1'b0, "R7", int'(o_tick), 0);
        chk(o_wave === 1'b1, "R7", int'(o_wave), 1);
        rst     = 1'b0;
        mod_hi  = m;
        cfg_sel = c;
        open_period(m, c);
        cnt  = 1;
        meas = 1;
        first_after_rst = 1;
    endtask

    initial begin
        do_reset(1'b0, 2'b00);

        // R1 / R2: every setting with both moduli held steady.
        tick_tag = "R5";
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 2; m++) begin
                repeat (3 * ((8 << c) + 1)) step(m[0], c[1:0]);
            end
        end

        // R3: modulus control changes every cycle, setting held.
        tick_tag = "R3";
        for (int i = 0; i < 300; i++) step(i[0], 2'b01);
        for (int i = 0; i < 300; i++) step((i % 7) == 0, 2'b00);
        for (int i = 0; i < 200; i++) step((i % 5) != 0, 2'b10);

        // R4: setting changes every few cycles.
        tick_tag = "R4";
        for (int i = 0; i < 700; i++) begin
            logic [1:0] cv;
            cv = 2'((i / 3) % 4);
            step(i[2], cv);
        end

        // R7: reset in the middle of a period, both moduli.
        tick_tag = "R7";
        repeat (13) step(1'b1, 2'b11);
        do_reset(1'b1, 2'b10);
        repeat (80) step(1'b0, 2'b10);
        repeat (5) step(1'b0, 2'b00);
        do_reset(1'b0, 2'b01);
        repeat (60) step(1'b1, 2'b01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule